// File: doc/BRIEF.md
# Maskable Interrupt Status Aggregator

This block gathers single-cycle event pulses from a timekeeping unit, plus a push-button level, into a 12-bit sticky status register. A flag stays set until software clears it. A mask register of the same width decides which flags may raise the single active-high interrupt line. The interrupt line is high whenever at least one set flag has its mask bit clear.

Software reaches the block through a plain byte-wide register port: a 4-bit address, a write strobe, write data and combinational read data. Mask and status each appear as a low byte and a high byte. Flags are cleared by writing ones to one of two acknowledge bytes. The push-button input is a level, and the block detects its rising edge internally. The other three sources arrive as pulses that are already clocked.

Top module: `irq_agg`

## Requirements
- R1: After reset the mask reads 0xFF at address 0 and 0x0F at address 1, both status bytes read 0x00, and `irq` is low.
- R2: `irq` is a registered signal. In each cycle it equals the OR over all bits of (status AND NOT mask) as they stood one clock earlier, so it follows any change to status or mask one clock later.
- R3: A write to address 0 replaces mask bits 7:0 with the data byte and leaves mask bits 11:8 unchanged.
- R4: A write to address 1 replaces mask bits 11:8 with data bits 3:0 and leaves mask bits 7:0 unchanged. Address 1 reads as {4'b0, mask[11:8]}.
- R5: A write to address 4 clears each status bit 7:0 whose data bit is one. A write to address 5 clears each status bit 11:8 whose data bit (n-8) is one. All other status bits stay as they were.
- R6: Addresses 4 and 5 always read 0x00. Addresses 6 to 15 read 0x00, and writes to them have no effect.
- R7: A one-cycle `tick_evt` sets status bit 8, `alarm_evt` sets bit 9 and `upd_err_evt` sets bit 10. Each bit then stays set until it is acknowledged, whether or not it is masked.
- R8: Status bit 11 is set only in a cycle where `button_in` is high and was low in the previous cycle. Holding the button high does not set the bit again after an acknowledge.
- R9: If an event and an acknowledge of the same status bit fall in the same cycle, the bit ends up set.
- R10: Address 2 reads status bits 7:0, and address 3 reads {4'b0, status[11:8]}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe, one write per cycle when high |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| tick_evt | input | 1 | Periodic timer event pulse |
| alarm_evt | input | 1 | Alarm match event pulse |
| upd_err_evt | input | 1 | Time-update error event pulse |
| button_in | input | 1 | Push-button level, synchronous to `clk` |
| irq | output | 1 | Active-high interrupt, registered |

## Verification
The assertions assume that every input, including `button_in`, is already synchronous to `clk` and stable around the rising edge. They also assume that each event source is a pulse sampled once per edge, so that a held level counts as a new event on every cycle. The stimulus changes all inputs only on the falling edge and raises each event for exactly one cycle. It holds the push button high across several cycles and across an acknowledge, which lets the edge-only rule be seen. It also lines up an event with an acknowledge of the same bit on a single edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int BYTE_W = 8;
    localparam int STAT_W = 12;
    localparam int HI_W   = STAT_W - BYTE_W;

    // register addresses
    localparam int A_MASK_LO = 0;
    localparam int A_MASK_HI = 1;
    localparam int A_STAT_LO = 2;
    localparam int A_STAT_HI = 3;
    localparam int A_ACK_LO  = 4;
    localparam int A_ACK_HI  = 5;

    // status bit positions of the event sources
    localparam int B_TICK  = 8;
    localparam int B_ALARM = 9;
    localparam int B_ERR   = 10;
    localparam int B_BTN   = 11;

    localparam logic [STAT_W-1:0] MASK_RST = {STAT_W{1'b1}};

endpackage

// File: rtl/irq_agg_edge.sv
module irq_agg_edge #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level,
    output logic [N-1:0] rise
);

    typedef struct packed {
        logic [N-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level;
        rise      = level & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] mask,
    output logic [STAT_W-1:0] clr_vec,
    output logic [BYTE_W-1:0] rd_data
);

    localparam logic [ADDR_W-1:0] AD_MLO = ADDR_W'(A_MASK_LO);
    localparam logic [ADDR_W-1:0] AD_MHI = ADDR_W'(A_MASK_HI);
    localparam logic [ADDR_W-1:0] AD_SLO = ADDR_W'(A_STAT_LO);
    localparam logic [ADDR_W-1:0] AD_SHI = ADDR_W'(A_STAT_HI);
    localparam logic [ADDR_W-1:0] AD_ALO = ADDR_W'(A_ACK_LO);
    localparam logic [ADDR_W-1:0] AD_AHI = ADDR_W'(A_ACK_HI);
    localparam int PAD_W = BYTE_W - HI_W;

    typedef struct packed {
        logic [STAT_W-1:0] mask;
    } regs_st_t;

    regs_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        clr_vec = '0;
        if (wr_en) begin
            unique case (addr)
                AD_MLO:  st_d.mask[BYTE_W-1:0]      = wr_data;
                AD_MHI:  st_d.mask[STAT_W-1:BYTE_W] = wr_data[HI_W-1:0];
                AD_ALO:  clr_vec[BYTE_W-1:0]        = wr_data;
                AD_AHI:  clr_vec[STAT_W-1:BYTE_W]   = wr_data[HI_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (addr)
            AD_MLO:  rd_data = st_q.mask[BYTE_W-1:0];
            AD_MHI:  rd_data = {{PAD_W{1'b0}}, st_q.mask[STAT_W-1:BYTE_W]};
            AD_SLO:  rd_data = status[BYTE_W-1:0];
            AD_SHI:  rd_data = {{PAD_W{1'b0}}, status[STAT_W-1:BYTE_W]};
            default: rd_data = '0;
        endcase
    end

    assign mask = st_q.mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.mask <= MASK_RST;
        else        st_q      <= st_d;
    end

endmodule

// File: rtl/irq_agg_status.sv
module irq_agg_status
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_vec,
    input  logic [STAT_W-1:0] clr_vec,
    input  logic [STAT_W-1:0] mask,
    output logic [STAT_W-1:0] status,
    output logic              irq
);

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic              irq;
    } stat_st_t;

    stat_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        // set takes precedence over clear
        st_d.status = (st_q.status & ~clr_vec) | set_vec;
        st_d.irq    = |(st_q.status & ~mask);
    end

    assign status = st_q.status;
    assign irq    = st_q.irq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/irq_agg.sv
module irq_agg
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              tick_evt,
    input  logic              alarm_evt,
    input  logic              upd_err_evt,
    input  logic              button_in,
    output logic              irq
);

    logic              btn_rise;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] mask_w;
    logic [STAT_W-1:0] status_w;

    irq_agg_edge #(.N(1)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (button_in),
        .rise  (btn_rise)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[B_TICK]  = tick_evt;
        set_vec[B_ALARM] = alarm_evt;
        set_vec[B_ERR]   = upd_err_evt;
        set_vec[B_BTN]   = btn_rise;
    end

    irq_agg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .status  (status_w),
        .mask    (mask_w),
        .clr_vec (clr_vec),
        .rd_data (rd_data)
    );

    irq_agg_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .mask    (mask_w),
        .status  (status_w),
        .irq     (irq)
    );

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [BYTE_W-1:0] wr_data,
    input logic [BYTE_W-1:0] rd_data,
    input logic              tick_evt,
    input logic              button_in,
    input logic [STAT_W-1:0] status,
    input logic [STAT_W-1:0] mask,
    input logic              irq
);

    localparam logic [ADDR_W-1:0] AD_MLO = ADDR_W'(A_MASK_LO);
    localparam logic [ADDR_W-1:0] AD_ALO = ADDR_W'(A_ACK_LO);
    localparam logic [ADDR_W-1:0] AD_AHI = ADDR_W'(A_ACK_HI);

    assert_irq_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |($past(status) & ~$past(mask)));

    assert_mask_hi_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AD_MLO) |=> mask[STAT_W-1:BYTE_W] == $past(mask[STAT_W-1:BYTE_W]));

    assert_ack_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == AD_ALO || addr == AD_AHI) |-> rd_data == '0);

    assert_tick_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_evt |=> status[B_TICK]);

    generate
        for (genvar b = 0; b < HI_W; b++) begin : g_sticky
            assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (status[BYTE_W+b] && !(wr_en && addr == AD_AHI && wr_data[b]))
                |=> status[BYTE_W+b]);
        end
    endgenerate

    assert_button_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[B_BTN]) |-> $past(button_in));

    assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_evt && wr_en && addr == AD_AHI && wr_data[B_TICK-BYTE_W]) |=> status[B_TICK]);

endmodule

bind irq_agg irq_agg_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .tick_evt  (tick_evt),
    .button_in (button_in),
    .status    (status_w),
    .mask      (mask_w),
    .irq       (irq)
);

// File: tb/irq_agg_tb_top.sv
module irq_agg_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       tick_evt = 1'b0;
    logic       alarm_evt = 1'b0;
    logic       upd_err_evt = 1'b0;
    logic       button_in = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    irq_agg dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (addr),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .tick_evt    (tick_evt),
        .alarm_evt   (alarm_evt),
        .upd_err_evt (upd_err_evt),
        .button_in   (button_in),
        .irq         (irq)
    );

    // {write, addr, data-or-expected, requirement number}
    localparam int NV = 18;
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 4'h0, 8'hFF, 4'd1},   // R1 mask lo reset
        {1'b0, 4'h1, 8'h0F, 4'd1},   // R1 mask hi reset
        {1'b0, 4'h2, 8'h00, 4'd1},   // R1 status lo reset
        {1'b0, 4'h3, 8'h00, 4'd1},   // R1 status hi reset
        {1'b1, 4'h0, 8'h5A, 4'd3},   // R3 write mask lo
        {1'b0, 4'h0, 8'h5A, 4'd3},
        {1'b0, 4'h1, 8'h0F, 4'd3},   // R3 hi kept
        {1'b1, 4'h1, 8'hF3, 4'd4},   // R4 write mask hi
        {1'b0, 4'h1, 8'h03, 4'd4},
        {1'b0, 4'h0, 8'h5A, 4'd4},   // R4 lo kept
        {1'b0, 4'h4, 8'h00, 4'd6},   // R6 ack lo reads zero
        {1'b0, 4'h5, 8'h00, 4'd6},   // R6 ack hi reads zero
        {1'b0, 4'h7, 8'h00, 4'd6},   // R6 unmapped
        {1'b0, 4'hF, 8'h00, 4'd6},
        {1'b1, 4'h1, 8'h00, 4'd4},
        {1'b0, 4'h1, 8'h00, 4'd4},
        {1'b1, 4'h0, 8'hFF, 4'd3},
        {1'b0, 4'h0, 8'hFF, 4'd3}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
        addr = a;
        #1;
        check(rd_data == exp, req, rd_data, exp);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(irq == 1'b0, "R1 irq after reset", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][16]) wr(VEC[i][15:12], VEC[i][11:4]);
            else rd_chk(VEC[i][15:12], VEC[i][11:4], $sformatf("R%0d vector %0d", VEC[i][3:0], i));
        end
        // bits 11:8 now unmasked

        // R7 tick sets bit 8, R2 one-cycle latency
        @(negedge clk); tick_evt = 1'b1;
        @(negedge clk); tick_evt = 1'b0;
        rd_chk(4'h3, 8'h01, "R7 tick sets bit 8");
        check(irq == 1'b0, "R2 irq not yet", irq, 0);
        @(negedge clk);
        check(irq == 1'b1, "R2 irq rises", irq, 1);
        repeat (4) @(negedge clk);
        rd_chk(4'h3, 8'h01, "R7 sticky");

        @(negedge clk); alarm_evt = 1'b1;
        @(negedge clk); alarm_evt = 1'b0;
        rd_chk(4'h3, 8'h03, "R7 alarm sets bit 9");
        @(negedge clk); upd_err_evt = 1'b1;
        @(negedge clk); upd_err_evt = 1'b0;
        rd_chk(4'h3, 8'h07, "R10 R7 error sets bit 10");
        rd_chk(4'h2, 8'h00, "R10 status lo");

        // R5 acknowledges
        wr(4'h5, 8'h02);
        rd_chk(4'h3, 8'h05, "R5 ack hi clears bit 9 only");
        wr(4'h4, 8'hFF);
        rd_chk(4'h3, 8'h05, "R5 ack lo leaves hi");
        wr(4'h5, 8'h05);
        rd_chk(4'h3, 8'h00, "R5 ack hi clears rest");
        check(irq == 1'b1, "R2 irq still high one cycle", irq, 1);
        @(negedge clk);
        check(irq == 1'b0, "R2 irq falls", irq, 0);

        // R2 masked flag recorded but no irq
        wr(4'h1, 8'h01);
        @(negedge clk); tick_evt = 1'b1;
        @(negedge clk); tick_evt = 1'b0;
        repeat (2) @(negedge clk);
        check(irq == 1'b0, "R2 masked no irq", irq, 0);
        rd_chk(4'h3, 8'h01, "R7 masked flag recorded");
        wr(4'h1, 8'h00);
        @(negedge clk);
        check(irq == 1'b1, "R2 unmask raises irq", irq, 1);
        wr(4'h5, 8'h01);

        // R8 button edge only
        @(negedge clk); button_in = 1'b1;
        @(negedge clk);
        rd_chk(4'h3, 8'h08, "R8 button rise sets bit 11");
        wr(4'h5, 8'h08);
        repeat (3) @(negedge clk);
        rd_chk(4'h3, 8'h00, "R8 held high no re-set");
        button_in = 1'b0;
        @(negedge clk); button_in = 1'b1;
        @(negedge clk);
        rd_chk(4'h3, 8'h08, "R8 second rise");
        wr(4'h5, 8'h08);
        button_in = 1'b0;

        // R9 event wins over same-cycle ack
        @(negedge clk); tick_evt = 1'b1;
        @(negedge clk); tick_evt = 1'b0;
        addr = 4'h5; wr_data = 8'h01; wr_en = 1'b1; tick_evt = 1'b1;
        @(negedge clk); wr_en = 1'b0; tick_evt = 1'b0;
        rd_chk(4'h3, 8'h01, "R9 event wins");

        // R6 writes to unmapped address ignored
        wr(4'h9, 8'hFF);
        rd_chk(4'h0, 8'hFF, "R6 unmapped write no effect lo");
        rd_chk(4'h1, 8'h00, "R6 unmapped write no effect hi");
        rd_chk(4'h3, 8'h01, "R6 unmapped write status");

        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(irq == 1'b0, "R1 irq cleared by reset", irq, 0);
        rd_chk(4'h1, 8'h0F, "R1 mask hi after reset");
        rd_chk(4'h3, 8'h00, "R1 status after reset");
        rst_n = 1'b1;
        @(negedge clk);

        summary();
        $finish;
    end

endmodule